// File: doc/BRIEF.md
# Subcode Sync and Q-Channel Capture

This block sits behind an EFM demodulator that hands over one eight-bit subcode symbol per frame, together with a word strobe and two flags. The flags mark the two special sync patterns that open each subcode block. The block finds the start of a block when the second sync pattern follows the first on the very next strobe. From that point it collects the Q channel bit of the following data frames into an 80-bit block and checks the block with a 16-bit CRC.

A finished block is copied into a read buffer, unless a host read is already under way. A host then pulls the block out serially. It drives a slow read clock, and the block presents one bit on its data line, moving to the next bit on every falling edge of that clock. An option puts the CRC verdict in front of the Q bits as a status bit. The verdict is also available as a level that stays stable between reads.

Top module: `subq_capture`

## Requirements
- R1: A strobe flagged as the second sync pattern that comes on the strobe right after one flagged as the first sync pattern is a valid sync. `sync_hit` goes high at that strobe and drops at the next strobe.
- R2: These events produce no `sync_hit` and leave block collection untouched: a first-sync strobe followed by any other strobe, and a second-sync strobe without a first-sync strobe just before it.
- R3: `sym` carries the channels with P in bit 7, Q in bit 6 and W in bit 0. Only bit 6 is collected. The other seven bits, and the whole symbol on strobes flagged as sync, have no effect on the captured block.
- R4: A valid sync empties the collection register and its counter. The next 80 unflagged strobes supply Q1 to Q80 in arrival order. Further strobes are ignored until the next valid sync.
- R5: When bit Q80 arrives, `crc_pass` takes a new value. It is 1 exactly when the CRC-16 (polynomial 0x1021, initial value 0, Q1 fed first) over Q1..Q64 equals the bitwise inverse of Q65..Q80, with Q65 as the most significant bit. Otherwise it is 0.
- R6: With `hdr_en` high when the block completes, `q_data` first shows the CRC verdict and then Q1 through Q80. It advances by one bit on each falling edge of `rd_clk`.
- R7: With `hdr_en` low when the block completes, `q_data` starts directly at Q1 and ends at Q80.
- R8: After the falling edge that follows the last bit, `q_data` stays 0 until another block is copied in.
- R9: A block that completes while a read is in progress is dropped. A read is in progress from its first falling edge until its last bit. `crc_pass` and the remaining read bits keep the earlier block.
- R10: Reset clears `sync_hit`, `crc_pass`, `q_data` and the collection counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Word strobe, one cycle per frame |
| sym | input | 8 | Subcode symbol, P in bit 7 to W in bit 0 |
| is_s0 | input | 1 | Strobed symbol is the first sync pattern |
| is_s1 | input | 1 | Strobed symbol is the second sync pattern |
| hdr_en | input | 1 | Put the CRC status bit ahead of the Q bits |
| rd_clk | input | 1 | Host read clock, slow relative to clk |
| sync_hit | output | 1 | Valid sync seen in the current frame |
| crc_pass | output | 1 | CRC verdict of the buffered block |
| q_data | output | 1 | Serial read data |

## Verification
The bench sends blocks with a correct CRC and blocks with a single corrupted bit. These two kinds separate a working checker from one that always passes or always fails. The status-bit option is tried both on and off, which shows whether the read starts at the verdict or at Q1. The sync patterns are also broken on purpose: a lone first pattern, a lone second pattern, a block cut short by a fresh sync, and surplus strobes after a full block. These show that only a matched pair restarts collection. A further block arrives during a partial read, which shows whether the buffer is protected. Random symbols fill the seven unused channels and the sync frames, so any leak of those bits into the block is exposed.

// File: rtl/subq_pkg.sv
package subq_pkg;

    localparam int Q_BITS    = 80;
    localparam int CRC_W     = 16;
    localparam int DATA_BITS = Q_BITS - CRC_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    // channel order of a subcode symbol, first channel in the top bit
    typedef struct packed {
        logic p;
        logic q;
        logic r;
        logic s;
        logic t;
        logic u;
        logic v;
        logic w;
    } subsym_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_ACTIVE,
        RD_DONE
    } rd_state_t;

    // bitwise CRC, most significant (earliest received) bit first
    function automatic logic [CRC_W-1:0] crc_calc(input logic [DATA_BITS-1:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = DATA_BITS - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

    // block layout: Q1 at the top bit, Q80 at bit 0
    function automatic logic crc_match(input logic [Q_BITS-1:0] blk);
        return crc_calc(blk[Q_BITS-1:CRC_W]) == ~blk[CRC_W-1:0];
    endfunction

endpackage

// File: rtl/subq_sync.sv
module subq_sync (
    input  logic clk,
    input  logic rst,
    input  logic sym_valid,
    input  logic is_s0,
    input  logic is_s1,
    output logic armed,
    output logic sync_now,
    output logic sync_hit
);

    assign sync_now = sym_valid && is_s1 && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            sync_hit <= 1'b0;
        end else if (sym_valid) begin
            armed    <= is_s0;
            sync_hit <= sync_now;
        end
    end

endmodule

// File: rtl/subq_collect.sv
module subq_collect #(
    parameter int Q_BITS = subq_pkg::Q_BITS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sync_now,
    input  logic                       sym_valid,
    input  logic                       is_sync,
    input  logic                       q_bit,
    output logic [$clog2(Q_BITS+1)-1:0] count,
    output logic                       blk_done,
    output logic [Q_BITS-1:0]          blk_next
);

    localparam int CW = $clog2(Q_BITS + 1);

    logic [Q_BITS-1:0] shreg;
    logic              take;

    assign take     = sym_valid && !is_sync && (count < CW'(Q_BITS));
    assign blk_next = {shreg[Q_BITS-2:0], q_bit};
    assign blk_done = take && (count == CW'(Q_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst || sync_now) begin
            shreg <= '0;
            count <= '0;
        end else if (take) begin
            shreg <= blk_next;
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/subq_reader.sv
module subq_reader
    import subq_pkg::*;
#(
    parameter int Q_BITS = subq_pkg::Q_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_en,
    input  logic              rd_clk,
    input  logic              blk_done,
    input  logic [Q_BITS-1:0] blk_next,
    output logic              crc_pass,
    output logic              busy,
    output logic              q_data
);

    localparam int IW = $clog2(Q_BITS + 1);

    rd_state_t         state;
    logic [IW-1:0]     idx;
    logic [IW-1:0]     last_idx;
    logic [IW-1:0]     pos;
    logic [Q_BITS-1:0] hold;
    logic              hdr;
    logic              rd_prev;
    logic              fall;

    assign fall     = rd_prev && !rd_clk;
    assign busy     = (state == RD_ACTIVE) && (idx != '0);
    assign last_idx = hdr ? IW'(Q_BITS) : IW'(Q_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RD_IDLE;
            idx      <= '0;
            hold     <= '0;
            hdr      <= 1'b0;
            crc_pass <= 1'b0;
            rd_prev  <= 1'b0;
        end else begin
            rd_prev <= rd_clk;
            if (blk_done && !busy) begin
                hold     <= blk_next;
                crc_pass <= crc_match(blk_next);
                hdr      <= hdr_en;
                state    <= RD_ACTIVE;
                idx      <= '0;
            end else if (state == RD_ACTIVE && fall) begin
                if (idx == last_idx) begin
                    state <= RD_DONE;
                    idx   <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        pos    = hdr ? IW'(Q_BITS) - idx : IW'(Q_BITS - 1) - idx;
        q_data = 1'b0;
        if (state == RD_ACTIVE) begin
            if (hdr && idx == '0) q_data = crc_pass;
            else                  q_data = hold[pos];
        end
    end

endmodule

// File: rtl/subq_capture.sv
module subq_capture
    import subq_pkg::*;
#(
    parameter int Q_BITS = subq_pkg::Q_BITS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_valid,
    input  logic [7:0] sym,
    input  logic       is_s0,
    input  logic       is_s1,
    input  logic       hdr_en,
    input  logic       rd_clk,
    output logic       sync_hit,
    output logic       crc_pass,
    output logic       q_data
);

    localparam int CW = $clog2(Q_BITS + 1);

    subsym_t           s;
    logic              sym_unused;
    logic              sync_armed;
    logic              sync_now;
    logic              rd_busy;
    logic              blk_done;
    logic [Q_BITS-1:0] blk_next;
    logic [CW-1:0]     q_count;

    assign s          = subsym_t'(sym);
    assign sym_unused = ^{s.p, s.r, s.s, s.t, s.u, s.v, s.w};

    subq_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .sym_valid(sym_valid),
        .is_s0    (is_s0),
        .is_s1    (is_s1),
        .armed    (sync_armed),
        .sync_now (sync_now),
        .sync_hit (sync_hit)
    );

    subq_collect #(.Q_BITS(Q_BITS)) u_collect (
        .clk      (clk),
        .rst      (rst),
        .sync_now (sync_now),
        .sym_valid(sym_valid),
        .is_sync  (is_s0 || is_s1),
        .q_bit    (s.q),
        .count    (q_count),
        .blk_done (blk_done),
        .blk_next (blk_next)
    );

    subq_reader #(.Q_BITS(Q_BITS)) u_reader (
        .clk      (clk),
        .rst      (rst),
        .hdr_en   (hdr_en),
        .rd_clk   (rd_clk),
        .blk_done (blk_done),
        .blk_next (blk_next),
        .crc_pass (crc_pass),
        .busy     (rd_busy),
        .q_data   (q_data)
    );

endmodule

// File: rtl/subq_capture_chk.sv
module subq_capture_chk #(
    parameter int Q_BITS = subq_pkg::Q_BITS
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        sym_valid,
    input logic                        is_s1,
    input logic                        sync_hit,
    input logic                        crc_pass,
    input logic                        q_data,
    input logic                        armed,
    input logic                        busy,
    input logic [$clog2(Q_BITS+1)-1:0] count
);

    // R1
    sync_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_hit) |-> $past(sym_valid && is_s1));

    // R2
    lone_s1_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && is_s1 && !armed) |=> !sync_hit);

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= ($clog2(Q_BITS+1))'(Q_BITS));

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(crc_pass));

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!crc_pass && !q_data && !sync_hit && count == '0));

endmodule

bind subq_capture subq_capture_chk #(.Q_BITS(Q_BITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sym_valid(sym_valid),
    .is_s1    (is_s1),
    .sync_hit (sync_hit),
    .crc_pass (crc_pass),
    .q_data   (q_data),
    .armed    (sync_armed),
    .busy     (rd_busy),
    .count    (q_count)
);

// File: tb/test_subq_capture.sv
`timescale 1ns/1ps
module test_subq_capture;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic [7:0] sym = '0;
    logic       is_s0 = 1'b0;
    logic       is_s1 = 1'b0;
    logic       hdr_en = 1'b0;
    logic       rd_clk = 1'b0;
    logic       sync_hit, crc_pass, q_data;

    int checks = 0;
    int failures = 0;
    logic got [0:81];

    always #2 clk = ~clk;

    subq_capture i_subq_capture (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym(sym),
        .is_s0(is_s0), .is_s1(is_s1), .hdr_en(hdr_en), .rd_clk(rd_clk),
        .sync_hit(sync_hit), .crc_pass(crc_pass), .q_data(q_data)
    );

    function automatic logic [15:0] ref_crc(input logic [63:0] d);
        logic [15:0] c = '0;
        for (int i = 63; i >= 0; i--) begin
            logic fb = c[15] ^ d[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic ref_ok(input logic [79:0] b);
        return ref_crc(b[79:16]) == ~b[15:0];
    endfunction

    function automatic logic [79:0] make_good();
        logic [63:0] d = {$urandom(), $urandom()};
        return {d, ~ref_crc(d)};
    endfunction

    // expected read bit i; block holds Q1 at bit 79
    function automatic logic exp_bit(input logic [79:0] b, input logic hdr, input int i);
        if (hdr) return (i == 0) ? ref_ok(b) : b[80 - i];
        return b[79 - i];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic frame(input logic q, input logic f0, input logic f1);
        logic [7:0] r;
        @(negedge clk);
        r = 8'($urandom());
        r[6] = q;
        sym = r; is_s0 = f0; is_s1 = f1; sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0; is_s0 = 1'b0; is_s1 = 1'b0; sym = 8'($urandom());
        @(negedge clk);
    endtask

    task automatic sync_pair();
        frame(1'b1, 1'b1, 1'b0);
        frame(1'b1, 1'b0, 1'b1);
    endtask

    task automatic data_frames(input logic [79:0] b, input int first, input int n);
        for (int i = first; i < first + n; i++) frame(b[79 - i], 1'b0, 1'b0);
    endtask

    task automatic send_block(input logic [79:0] b);
        sync_pair();
        data_frames(b, 0, 80);
    endtask

    // sample then pulse rd_clk, for bit positions first..first+n-1
    task automatic read_bits(input int first, input int n);
        for (int i = first; i < first + n; i++) begin
            @(negedge clk);
            got[i] = q_data;
            rd_clk = 1'b1;
            repeat (2) @(negedge clk);
            rd_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic check_read(input logic [79:0] b, input logic hdr, input string req);
        int n = hdr ? 81 : 80;
        int bad = 0;
        logic [79:0] a = '0;
        logic [79:0] e = '0;
        for (int i = 0; i < n; i++) begin
            if (got[i] !== exp_bit(b, hdr, i)) bad++;
            if (i >= n - 80) begin
                a[79 - (i - (n - 80))] = got[i];
                e[79 - (i - (n - 80))] = exp_bit(b, hdr, i);
            end
        end
        chk(bad == 0 && (!hdr || got[0] === ref_ok(b)), req, a, e);
    endtask

    task automatic full_read(input logic [79:0] b, input logic hdr, input string req);
        read_bits(0, hdr ? 81 : 80);
        check_read(b, hdr, req);
        @(negedge clk);
        // R8
        chk(q_data === 1'b0, "R8 idle after last bit", 80'(q_data), 80'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [79:0] a, b, c;
        logic        h;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        chk(sync_hit === 1'b0, "R10 sync_hit reset", 80'(sync_hit), 80'(0));
        chk(crc_pass === 1'b0, "R10 crc_pass reset", 80'(crc_pass), 80'(0));
        chk(q_data === 1'b0, "R10 q_data reset", 80'(q_data), 80'(0));

        // R1: matched pair
        frame(1'b0, 1'b1, 1'b0);
        chk(sync_hit === 1'b0, "R1 no hit after first pattern", 80'(sync_hit), 80'(0));
        frame(1'b0, 1'b0, 1'b1);
        chk(sync_hit === 1'b1, "R1 hit after pair", 80'(sync_hit), 80'(1));
        frame(1'b0, 1'b0, 1'b0);
        chk(sync_hit === 1'b0, "R1 hit drops at next strobe", 80'(sync_hit), 80'(0));

        // R5 R6: good block with status bit
        hdr_en = 1'b1;
        a = make_good();
        send_block(a);
        chk(crc_pass === 1'b1, "R5 good block passes", 80'(crc_pass), 80'(1));
        full_read(a, 1'b1, "R6 status bit then Q1..Q80");

        // R5: single bit corrupted
        b = make_good();
        b[40] = ~b[40];
        send_block(b);
        chk(crc_pass === 1'b0, "R5 corrupted block fails", 80'(crc_pass), 80'(0));
        full_read(b, 1'b1, "R6 status bit zero on bad block");

        // R7: no status bit
        hdr_en = 1'b0;
        c = make_good();
        send_block(c);
        full_read(c, 1'b0, "R7 read starts at Q1");

        // R2: lone first pattern, lone second pattern inside a block
        a = make_good();
        sync_pair();
        data_frames(a, 0, 40);
        frame(1'b1, 1'b1, 1'b0);
        data_frames(a, 40, 1);
        chk(sync_hit === 1'b0, "R2 first pattern not followed", 80'(sync_hit), 80'(0));
        frame(1'b1, 1'b0, 1'b1);
        chk(sync_hit === 1'b0, "R2 lone second pattern", 80'(sync_hit), 80'(0));
        data_frames(a, 41, 39);
        chk(crc_pass === 1'b1, "R2 collection kept through broken sync", 80'(crc_pass), 80'(1));
        full_read(a, 1'b0, "R2 R3 block intact");

        // R4: restart by fresh sync, surplus strobes ignored
        sync_pair();
        for (int i = 0; i < 30; i++) frame(1'($urandom()), 1'b0, 1'b0);
        b = make_good();
        send_block(b);
        for (int i = 0; i < 6; i++) frame(1'($urandom()), 1'b0, 1'b0);
        chk(crc_pass === 1'b1, "R4 restarted block passes", 80'(crc_pass), 80'(1));
        full_read(b, 1'b0, "R4 restart and surplus ignored");

        // R9: block arrives mid-read
        hdr_en = 1'b1;
        a = make_good();
        send_block(a);
        read_bits(0, 3);
        hdr_en = 1'b0;
        c = make_good();
        c[5] = ~c[5];
        send_block(c);
        chk(crc_pass === 1'b1, "R9 verdict kept during read", 80'(crc_pass), 80'(1));
        read_bits(3, 78);
        check_read(a, 1'b1, "R9 read finishes on old block");

        // R3 R5 R6 R7: random blocks
        for (int k = 0; k < 6; k++) begin
            h = 1'($urandom());
            hdr_en = h;
            a = make_good();
            if ($urandom() % 2) a[$urandom() % 80] ^= 1'b1;
            send_block(a);
            chk(crc_pass === ref_ok(a), "R5 random verdict", 80'(crc_pass), 80'(ref_ok(a)));
            full_read(a, h, h ? "R6 random read" : "R7 random read");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule